// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This block keeps wall-clock time as a 48-bit count of seconds. A prescaler counts ticks of a 32768 Hz enable, and each time it wraps the seconds count advances by one. Software reaches the count, a 48-bit alarm compare value, a control word and the event logic through a simple single-cycle 32-bit register port. Read data is combinational from `addr_i` while `req_i` is high and `we_i` is low. All side effects take place at the next rising clock edge.

The 48-bit count does not fit in one bus word. A latch mode makes a two-read access coherent: a read of the low word captures the upper 16 bits, and the following high-word read returns the captured value. Two event sources exist: the alarm match and an external event input. Each has a sticky flag. The flags are cleared by writing ones. Enables are changed only through separate set and clear addresses. The interrupt is asserted while any enabled flag is set.

Registers by word address: 0 count low, 1 count high, 2 alarm low, 3 alarm high, 4 control, 5 raw flags, 6 masked flags, 7 enable set, 8 enable clear.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset the following hold. The count is 0. The alarm value is all ones. The control word, the flags and the enables are 0. `irq_o` is low. Unmapped addresses read 0.
- R2: The prescaler advances only on cycles where `tick_i` is high. The count increments by one on the tick that takes the prescaler from 2^PRESC_W-1 back to 0.
- R3: The count wraps from 2^48-1 to 0. Address 0 reads count bits 31:0. Address 1 reads count bits 47:32 in bits 15:0, with zeros above.
- R4: A write to address 0 loads count bits 31:0 and clears the prescaler. A write to address 1 loads count bits 47:32 from data bits 15:0 and ignores data bits 31:16. No increment happens in a cycle that writes either count word.
- R5: The control word at address 4 holds a latch mode in bits 25:24. When the mode is 2, a read of address 0 captures count bits 47:32. The next read of address 1 returns the captured value and releases the capture.
- R6: When the latch mode is not 2, a read of address 0 captures nothing. A read of address 1 returns the live count bits 47:32.
- R7: The alarm value is written through addresses 2 (bits 31:0) and 3 (bits 47:32 from data bits 15:0). Flag bit 0 sets on the clock edge after the count first becomes equal to the alarm value. It sets once for each entry into equality.
- R8: Address 5 reads the flags in bits 1:0. Writing a 1 to a bit at address 5 or at address 6 clears that flag. A flag that is set and cleared in the same cycle ends up set.
- R9: A high `alt_evt_i` sets flag bit 1 at the next edge.
- R10: Writing ones to address 7 sets the matching enable bits. Writing ones to address 8 clears them. Both addresses read the enables in bits 1:0. Address 6 reads the flags ANDed with the enables.
- R11: `irq_o` is high exactly while at least one flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32768 Hz tick enable, one cycle wide |
| alt_evt_i | input | 1 | Second event source, sets flag bit 1 |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while a read is requested |
| irq_o | output | 1 | Interrupt, high while an enabled flag is set |

## Verification
The properties assume that a single access is requested per cycle and that its address and data are stable through the edge that samples them. The bench drives each access for exactly one cycle, with changes made away from the edge. The properties also assume that `tick_i` carries no timing meaning beyond the prescaler. The bench varies the tick density and runs the prescaler at a reduced width so that seconds pass quickly. Latch checks put low/high read pairs across a carry into bit 32. The bench enters and leaves latch mode only between pairs, never inside one.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned NUM_EVT = 2;
  localparam int unsigned FRZ_LSB = 24;
  localparam logic [1:0]  FRZ_LO_LATCH = 2'd2;

  localparam logic [ADDR_W-1:0] ADR_CNT_LO  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_CNT_HI  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_ALM_LO  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_ALM_HI  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_EVT_RAW = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_EVT_MSK = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_EN_SET  = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_EN_CLR  = 4'd8;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESC_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic wrap_o
);
  localparam logic [PRESC_W-1:0] PMAX = '1;

  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = tick_i & ~clr_i & (cnt_q == PMAX);
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [CNT_W-DATA_W-1:0] hi_i,
  input  logic              inc_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (ld_lo_i) cnt_q[DATA_W-1:0] <= lo_i;
    else if (ld_hi_i) cnt_q[CNT_W-1:DATA_W] <= hi_i;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_evt_ctrl.sv
module rtc_evt_ctrl #(
  parameter int unsigned NUM_EVT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  input  logic [NUM_EVT-1:0] en_set_i,
  input  logic [NUM_EVT-1:0] en_clr_i,
  output logic [NUM_EVT-1:0] flags_o,
  output logic [NUM_EVT-1:0] en_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] flags_q, en_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_q[i] <= 1'b0;
        en_q[i]    <= 1'b0;
      end else begin
        // set wins over a same-cycle clear
        flags_q[i] <= set_i[i] | (flags_q[i] & ~clr_i[i]);
        en_q[i]    <= en_set_i[i] | (en_q[i] & ~en_clr_i[i]);
      end
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = |(flags_q & en_q);
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_sec_pkg::*;
#(
  parameter int unsigned PRESC_W = 15,
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              alt_evt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic wr, rd;
  logic wr_cnt_lo, wr_cnt_hi, wr_alm_lo, wr_alm_hi, wr_ctrl;
  logic wr_evt_clr, wr_en_set, wr_en_clr;
  logic rd_cnt_lo, rd_cnt_hi;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign wr_cnt_lo  = wr & (addr_i == ADR_CNT_LO);
  assign wr_cnt_hi  = wr & (addr_i == ADR_CNT_HI);
  assign wr_alm_lo  = wr & (addr_i == ADR_ALM_LO);
  assign wr_alm_hi  = wr & (addr_i == ADR_ALM_HI);
  assign wr_ctrl    = wr & (addr_i == ADR_CTRL);
  assign wr_evt_clr = wr & ((addr_i == ADR_EVT_RAW) | (addr_i == ADR_EVT_MSK));
  assign wr_en_set  = wr & (addr_i == ADR_EN_SET);
  assign wr_en_clr  = wr & (addr_i == ADR_EN_CLR);
  assign rd_cnt_lo  = rd & (addr_i == ADR_CNT_LO);
  assign rd_cnt_hi  = rd & (addr_i == ADR_CNT_HI);

  // seconds timebase
  logic sec_tick;
  logic [CNT_W-1:0] sec_cnt;

  rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_cnt_lo),
    .tick_i (tick_i),
    .wrap_o (sec_tick)
  );

  rtc_sec_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_lo_i (wr_cnt_lo),
    .ld_hi_i (wr_cnt_hi),
    .lo_i    (wdata_i),
    .hi_i    (wdata_i[HI_W-1:0]),
    .inc_i   (sec_tick & ~wr_cnt_hi),
    .cnt_o   (sec_cnt)
  );

  // control and alarm compare value
  logic [1:0]       frz_mode_q;
  logic [CNT_W-1:0] alm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_mode_q <= '0;
      alm_q      <= '1;
    end else begin
      if (wr_ctrl)   frz_mode_q <= wdata_i[FRZ_LSB +: 2];
      if (wr_alm_lo) alm_q[DATA_W-1:0] <= wdata_i;
      if (wr_alm_hi) alm_q[CNT_W-1:DATA_W] <= wdata_i[HI_W-1:0];
    end
  end

  // split-read capture of the upper word
  logic            frozen_q;
  logic [HI_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      snap_q   <= '0;
    end else if (rd_cnt_lo && frz_mode_q == FRZ_LO_LATCH) begin
      frozen_q <= 1'b1;
      snap_q   <= sec_cnt[CNT_W-1:DATA_W];
    end else if (rd_cnt_hi) begin
      frozen_q <= 1'b0;
    end
  end

  // alarm edge detect
  logic alarm_hit, match_q;
  assign alarm_hit = (sec_cnt == alm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= alarm_hit;
  end

  logic [NUM_EVT-1:0] evt_set, evt_clr, en_set, en_clr, flags, en;

  assign evt_set = {alt_evt_i, alarm_hit & ~match_q};
  assign evt_clr = wr_evt_clr ? wdata_i[NUM_EVT-1:0] : '0;
  assign en_set  = wr_en_set  ? wdata_i[NUM_EVT-1:0] : '0;
  assign en_clr  = wr_en_clr  ? wdata_i[NUM_EVT-1:0] : '0;

  rtc_evt_ctrl #(.NUM_EVT(NUM_EVT)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt_set),
    .clr_i    (evt_clr),
    .en_set_i (en_set),
    .en_clr_i (en_clr),
    .flags_o  (flags),
    .en_o     (en),
    .irq_o    (irq_o)
  );

  // read mux
  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        ADR_CNT_LO:  rdata_o = sec_cnt[DATA_W-1:0];
        ADR_CNT_HI:  rdata_o[HI_W-1:0] = frozen_q ? snap_q : sec_cnt[CNT_W-1:DATA_W];
        ADR_ALM_LO:  rdata_o = alm_q[DATA_W-1:0];
        ADR_ALM_HI:  rdata_o[HI_W-1:0] = alm_q[CNT_W-1:DATA_W];
        ADR_CTRL:    rdata_o[FRZ_LSB +: 2] = frz_mode_q;
        ADR_EVT_RAW: rdata_o[NUM_EVT-1:0] = flags;
        ADR_EVT_MSK: rdata_o[NUM_EVT-1:0] = flags & en;
        ADR_EN_SET,
        ADR_EN_CLR:  rdata_o[NUM_EVT-1:0] = en;
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_sec_core_chk.sv
module rtc_sec_core_chk
  import rtc_sec_pkg::*;
#(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned DATA_W = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_i,
  input logic                     we_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [DATA_W-1:0]        wdata_i,
  input logic                     alt_evt_i,
  input logic                     irq_i,
  input logic                     sec_i,
  input logic [CNT_W-1:0]         cnt_i,
  input logic [CNT_W-1:0]         alm_i,
  input logic                     match_i,
  input logic                     frozen_i,
  input logic [CNT_W-DATA_W-1:0]  snap_i,
  input logic [NUM_EVT-1:0]       flags_i,
  input logic [NUM_EVT-1:0]       en_i
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic wr, rd, wr_cnt;
  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign wr_cnt = wr & ((addr_i == ADR_CNT_LO) | (addr_i == ADR_CNT_HI));

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_i && !wr_cnt) |=> $stable(cnt_i)); // R2

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_i && !wr_cnt) |=> (cnt_i == $past(cnt_i) + 1'b1)); // R3

  AST_LO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADR_CNT_LO) |=> (cnt_i[DATA_W-1:0] == $past(wdata_i))); // R4

  AST_HI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADR_CNT_HI) |=> (cnt_i[CNT_W-1:DATA_W] == $past(wdata_i[HI_W-1:0]))); // R4

  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_i && !(rd && addr_i == ADR_CNT_LO)) |=> $stable(snap_i)); // R5

  AST_HI_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == ADR_CNT_HI) |=> !frozen_i); // R5

  AST_ALARM_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == alm_i && !match_i) |=> flags_i[0]); // R7

  AST_ALT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_evt_i |=> flags_i[1]); // R9

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADR_EN_SET && wdata_i[0]) |=> en_i[0]); // R10

  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !irq_i); // R11
endmodule

bind rtc_sec_core rtc_sec_core_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .alt_evt_i (alt_evt_i),
  .irq_i     (irq_o),
  .sec_i     (sec_tick),
  .cnt_i     (sec_cnt),
  .alm_i     (alm_q),
  .match_i   (match_q),
  .frozen_i  (frozen_q),
  .snap_i    (snap_q),
  .flags_i   (flags),
  .en_i      (en)
);

// File: tb/rtc_sec_core_test.sv
module rtc_sec_core_test;
  localparam int PW = 4;
  localparam int PMAX = (1 << PW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        alt = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_mode = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_sec_core #(.PRESC_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .alt_evt_i(alt),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // reference model
  logic [47:0] m_cnt, m_alm;
  logic [15:0] m_snap;
  logic [1:0]  m_mode, m_flags, m_en;
  logic        m_frozen, m_match;
  int          m_presc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_alm = '1; m_snap = 0; m_mode = 0; m_flags = 0; m_en = 0;
      m_frozen = 0; m_match = 0; m_presc = 0;
    end else begin
      bit w, r, hit, sec;
      logic [1:0] clr;
      w = req && we; r = req && !we;
      hit = (m_cnt == m_alm);
      clr = (w && (addr == 5 || addr == 6)) ? wdata[1:0] : 2'b00;
      m_flags = (m_flags & ~clr) | {alt, hit && !m_match};
      m_match = hit;
      if (w && addr == 7) m_en = m_en | wdata[1:0];
      if (w && addr == 8) m_en = m_en & ~wdata[1:0];
      if (r && addr == 0 && m_mode == 2) begin m_frozen = 1; m_snap = m_cnt[47:32]; end
      else if (r && addr == 1) m_frozen = 0;
      sec = 0;
      if (w && addr == 0) m_presc = 0;
      else if (tick) begin
        if (m_presc == PMAX) sec = 1;
        m_presc = (m_presc + 1) % (PMAX + 1);
      end
      if (w && addr == 0) m_cnt[31:0] = wdata;
      else if (w && addr == 1) m_cnt[47:32] = wdata[15:0];
      else if (sec) m_cnt = m_cnt + 1;
      if (w && addr == 2) m_alm[31:0] = wdata;
      if (w && addr == 3) m_alm[47:32] = wdata[15:0];
      if (w && addr == 4) m_mode = wdata[25:24];
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      0: return m_cnt[31:0];
      1: return {16'h0, m_frozen ? m_snap : m_cnt[47:32]};
      2: return m_alm[31:0];
      3: return {16'h0, m_alm[47:32]};
      4: return {6'h0, m_mode, 24'h0};
      5: return {30'h0, m_flags};
      6: return {30'h0, m_flags & m_en};
      7, 8: return {30'h0, m_en};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // irq compared every cycle (R11)
  always @(negedge clk) if (rst_n && !done) check("R11 irq", {31'h0, irq}, {31'h0, |(m_flags & m_en)});

  initial begin : tick_gen
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      tick = (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? (k % 3 == 0) : 1'b0;
    end
  end

  task automatic rd(input logic [3:0] a, input string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 check(tag, rdata, exp_rd(a));
    @(posedge clk); #1 req = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit with_alt = 0);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; alt = with_alt;
    @(posedge clk); #1 req = 0; we = 0; alt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 16; a++) rd(a[3:0], "R1 reset");
    // R2 counting, dense ticks then sparse ticks
    idle(40);
    rd(0, "R2 lo"); rd(1, "R3 hi");
    tick_mode = 1; idle(100);
    rd(0, "R2 sparse"); tick_mode = 2; idle(30); rd(0, "R2 no tick");
    tick_mode = 0;
    // R4 load with reserved high bits
    wr(0, 32'hFFFF_FFFE); wr(1, 32'hABCD_0012);
    rd(1, "R4 hi load"); rd(0, "R4 lo load");
    // R5 latch mode across a carry into bit 32
    wr(4, 32'h0200_0000); rd(4, "R5 ctrl");
    for (int i = 0; i < 30; i++) begin
      rd(0, "R5 lo"); idle(i % 5); rd(1, "R5 hi");
    end
    // R6 live reads
    wr(0, 32'hFFFF_FFFF); wr(4, 32'h0100_0000);
    for (int i = 0; i < 20; i++) begin
      rd(0, "R6 lo"); idle(i % 4); rd(1, "R6 hi");
    end
    // R3 48-bit wrap
    wr(0, 32'hFFFF_FFFF); wr(1, 32'h0000_FFFF);
    rd(1, "R3 pre wrap"); idle(20); rd(0, "R3 wrap lo"); rd(1, "R3 wrap hi");
    // R7 alarm two seconds ahead
    wr(3, {16'h0, m_cnt[47:32]}); wr(2, m_cnt[31:0] + 2);
    rd(2, "R7 alm lo"); rd(3, "R7 alm hi");
    wr(7, 32'h1); rd(7, "R10 en set");
    idle(50);
    rd(5, "R7 raw"); rd(6, "R10 masked");
    wr(6, 32'h1); rd(5, "R8 w1c");
    // R9 alt event with a same-cycle clear of bit 1: set wins (R8)
    wr(5, 32'h2, 1); rd(5, "R8 set beats clear");
    rd(6, "R10 masked alt off");
    wr(7, 32'h2); rd(8, "R10 en read"); rd(6, "R9 masked alt on");
    wr(5, 32'h3); rd(5, "R8 clear both");
    wr(8, 32'h3); rd(7, "R10 en clr");
    wr(5, 32'h0, 1); rd(5, "R9 alt raw");
    idle(5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule